// File: doc/BRIEF.md
# Cartridge Mapper Lockout Sequencer

This block sits on the cartridge side of a handheld console's CPU bus. It watches every CPU read and write, including work-RAM traffic that the cartridge only snoops. It walks a three-stage boot lockout: locked-monochrome, then locked-color, then unlocked. While locked it alters header-window reads, so a console boot check sees a different header image in each stage.

Each read is translated to a flat ROM address. Addresses below 0x4000 map to the fixed bank. The next 16 KiB window maps to the switchable bank, whose number arrives on an input. Anything above that window is reported as open bus. Header reads are rewritten in two steps: address bit 7 is forced high in the color-locked stage, then the low byte passes through a fixed bit-swap stage chosen by parameters. A skip-boot input jumps straight to the unlocked stage.

Top module: `cart_lockout_seq`

## Requirements
- R1: After a synchronous reset the `state` port reads 0 (locked-monochrome) and the transition count is zero. The stage encoding is 0 = locked-monochrome, 1 = locked-color, 2 = unlocked. The value 3 never appears.
- R2: The stage never moves backwards. Once unlocked, no read or write changes it.
- R3: In locked-monochrome, a read at 0xC000 or above moves the block to locked-color and clears the count. A read at 0xBFFF or below does not trigger this step.
- R4: In locked-monochrome, a write with address bits 15:13 equal to 3'b110 (0xC000–0xDFFF) moves the block to locked-color and clears the count. Writes anywhere else have no effect on the stage or the count.
- R5: In either locked stage, a read with (address AND 0x8700) == 0x0100 adds one to the count. The 49th such read (count 0x31) advances the stage by one step and zeroes the count. Writes never count.
- R6: For a read in 0x0100–0x01FF, address bit 7 is forced to 1 only when the stage that results from this read is locked-color.
- R7: Every read in 0x0100–0x01FF passes through the default bit swap after the forcing step: low-byte bit 0 is exchanged with bit 6, and bit 1 with bit 4. This holds in every stage.
- R8: A read below 0x4000 gives `rom_addr` = {8'h00, translated address bits 13:0} with `bank_sel` = 0 and `open_bus` = 0.
- R9: A read in 0x4000–0x7FFF gives `rom_addr` = {`bank_num`, address bits 13:0} with `bank_sel` = 1 and `open_bus` = 0.
- R10: A read at 0x8000 or above gives `open_bus` = 1, `bank_sel` = 0 and `rom_addr` = 0.
- R11: `skip_boot` sets the stage to unlocked on the next clock edge. It takes priority over every other event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| rd_stb | input | 1 | CPU read strobe, one cycle per access |
| wr_stb | input | 1 | CPU write strobe, one cycle per access |
| skip_boot | input | 1 | Forces the unlocked stage |
| bank_num | input | 8 | Switchable bank number |
| rom_addr | output | 22 | Translated ROM byte address |
| bank_sel | output | 1 | 1 when the switchable bank is addressed |
| open_bus | output | 1 | 1 when the read is outside cartridge ROM |
| state | output | 2 | Current lockout stage |

## Verification
The assertions assume that one CPU access is presented per strobe cycle. They also assume that `cpu_addr` and the strobes are steady around the rising edge. The bench keeps to this by changing inputs only on the falling edge. It raises at most one strobe per cycle, except in one case that deliberately combines `skip_boot` with a trigger read. The header-bit assertion relies on the default swap positions, and the bench never overrides them.

// File: rtl/clks_pkg.sv
package clks_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        LK_MONO  = 2'd0,
        LK_COLOR = 2'd1,
        LK_OPEN  = 2'd2
    } lock_e;

    localparam logic [ADDR_W-1:0] HI_RD_BASE   = 16'hC000;
    localparam logic [2:0]        WRAM_WR_TAG  = 3'b110;
    localparam logic [ADDR_W-1:0] QUAL_MASK    = 16'h8700;
    localparam logic [ADDR_W-1:0] QUAL_MATCH   = 16'h0100;
    localparam logic [7:0]        HDR_PAGE     = 8'h01;

    typedef struct packed {
        logic bank_hi;
        logic open;
    } map_flags_t;

    function automatic lock_e lock_step(input lock_e s);
        case (s)
            LK_MONO:  return LK_COLOR;
            default:  return LK_OPEN;
        endcase
    endfunction

    function automatic logic [7:0] swap_pair(input logic [7:0] v,
                                             input int a, input int b);
        logic [7:0] r;
        r    = v;
        r[a] = v[b];
        r[b] = v[a];
        return r;
    endfunction

endpackage

// File: rtl/lock_fsm.sv
module lock_fsm
    import clks_pkg::*;
#(
    parameter int UNLOCK_CNT = 49
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              skip,
    output lock_e             st_q,
    output lock_e             st_nx
);
    localparam int CNT_W = $clog2(UNLOCK_CNT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_CNT - 1);

    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic hi_read, wram_write, qual_read;

    assign hi_read    = rd && (addr >= HI_RD_BASE);
    assign wram_write = wr && (addr[ADDR_W-1 -: 3] == WRAM_WR_TAG);
    assign qual_read  = rd && ((addr & QUAL_MASK) == QUAL_MATCH);

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        if (skip) begin
            st_nx  = LK_OPEN;
            cnt_nx = '0;
        end else if (st_q == LK_MONO && (hi_read || wram_write)) begin
            st_nx  = LK_COLOR;
            cnt_nx = '0;
        end else if (st_q != LK_OPEN && qual_read) begin
            if (cnt_q == LAST) begin
                st_nx  = lock_step(st_q);
                cnt_nx = '0;
            end else begin
                cnt_nx = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_MONO;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/hdr_xlate.sv
module hdr_xlate
    import clks_pkg::*;
#(
    parameter bit UNSCRAMBLE = 1'b1,
    parameter int SW0_A = 0,
    parameter int SW0_B = 6,
    parameter int SW1_A = 1,
    parameter int SW1_B = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  lock_e             st_eff,
    output logic [ADDR_W-1:0] addr_x
);
    logic       in_hdr;
    logic [7:0] lo_forced, lo_out;

    assign in_hdr = (addr[ADDR_W-1:8] == HDR_PAGE);

    always_comb begin
        lo_forced = addr[7:0];
        if (st_eff == LK_COLOR) lo_forced[7] = 1'b1;
    end

    generate
        if (UNSCRAMBLE) begin : g_swap
            assign lo_out = swap_pair(swap_pair(lo_forced, SW0_A, SW0_B), SW1_A, SW1_B);
        end else begin : g_pass
            assign lo_out = lo_forced;
        end
    endgenerate

    assign addr_x = in_hdr ? {addr[ADDR_W-1:8], lo_out} : addr;
endmodule

// File: rtl/bank_map.sv
module bank_map
    import clks_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 14
) (
    input  logic [ADDR_W-1:0]       addr_x,
    input  logic [BANK_W-1:0]       bank_num,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    output map_flags_t              flags
);
    always_comb begin
        flags = '0;
        if (addr_x[ADDR_W-1]) begin
            flags.open = 1'b1;
            rom_addr   = '0;
        end else if (addr_x[OFS_W]) begin
            flags.bank_hi = 1'b1;
            rom_addr      = {bank_num, addr_x[OFS_W-1:0]};
        end else begin
            rom_addr = {{BANK_W{1'b0}}, addr_x[OFS_W-1:0]};
        end
    end
endmodule

// File: rtl/cart_lockout_seq.sv
module cart_lockout_seq
    import clks_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int OFS_W      = 14,
    parameter int UNLOCK_CNT = 49,
    parameter bit UNSCRAMBLE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             cpu_addr,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic                    skip_boot,
    input  logic [BANK_W-1:0]       bank_num,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    output logic                    bank_sel,
    output logic                    open_bus,
    output logic [1:0]              state
);
    lock_e             st_q, st_nx;
    logic [ADDR_W-1:0] addr_x;
    map_flags_t        flags;

    lock_fsm #(.UNLOCK_CNT(UNLOCK_CNT)) i_fsm (
        .clk(clk), .rst(rst), .addr(cpu_addr), .rd(rd_stb), .wr(wr_stb),
        .skip(skip_boot), .st_q(st_q), .st_nx(st_nx)
    );

    hdr_xlate #(.UNSCRAMBLE(UNSCRAMBLE)) i_hdr (
        .addr(cpu_addr), .st_eff(st_nx), .addr_x(addr_x)
    );

    bank_map #(.BANK_W(BANK_W), .OFS_W(OFS_W)) i_map (
        .addr_x(addr_x), .bank_num(bank_num), .rom_addr(rom_addr), .flags(flags)
    );

    assign bank_sel = flags.bank_hi;
    assign open_bus = flags.open;
    assign state    = st_q;
endmodule

// File: rtl/lockout_chk.sv
module lockout_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic        skip_boot,
    input logic [7:0]  bank_num,
    input logic [21:0] rom_addr,
    input logic        bank_sel,
    input logic        open_bus,
    input logic [1:0]  state
);
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3);

    // R2
    state_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state >= $past(state));

    // R3
    mono_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && rd_stb && !skip_boot && cpu_addr >= 16'hC000) |=> state == 2'd1);

    // R4
    mono_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && wr_stb && !skip_boot && cpu_addr[15:13] == 3'b110) |=> state == 2'd1);

    // R11
    skip_boot_chk: assert property (@(posedge clk) disable iff (rst)
        skip_boot |=> state == 2'd2);

    // R6
    open_no_force_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && cpu_addr[15:8] == 8'h01) |-> rom_addr[7] == cpu_addr[7]);

    // R9
    bank_window_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b01) |-> (bank_sel && rom_addr[21:14] == bank_num));

    // R10
    open_bus_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15] |-> (open_bus && !bank_sel));
endmodule

bind cart_lockout_seq lockout_chk i_lockout_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .skip_boot(skip_boot), .bank_num(bank_num), .rom_addr(rom_addr),
    .bank_sel(bank_sel), .open_bus(open_bus), .state(state)
);

// File: tb/test_cart_lockout_seq.sv
module test_cart_lockout_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, skip_boot = 1'b0;
    logic [7:0]  bank_num = '0;
    logic [21:0] rom_addr;
    logic        bank_sel, open_bus;
    logic [1:0]  state;

    int checks = 0, failures = 0;
    int m_st = 0, m_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cart_lockout_seq i_cart_lockout_seq (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .skip_boot(skip_boot), .bank_num(bank_num), .rom_addr(rom_addr),
        .bank_sel(bank_sel), .open_bus(open_bus), .state(state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] unswap(input logic [7:0] l);
        return {l[7], l[0], l[5], l[1], l[3], l[2], l[4], l[6]};
    endfunction

    task automatic model_step(input logic [15:0] a, input bit rd, input bit wr, input bit sk,
                              output int nst, output int ncnt);
        nst = m_st; ncnt = m_cnt;
        if (sk) begin
            nst = 2; ncnt = 0;
        end else if (m_st == 0 && ((rd && a >= 16'hC000) || (wr && a >= 16'hC000 && a <= 16'hDFFF))) begin
            nst = 1; ncnt = 0;
        end else if (m_st != 2 && rd && (a & 16'h8700) == 16'h0100) begin
            if (m_cnt == 48) begin nst = m_st + 1; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end
    endtask

    task automatic check_map(input logic [15:0] a, input int est);
        logic [21:0] exp_rom;
        logic [7:0]  lo;
        string       tag;
        bit          exp_sel, exp_open;
        exp_sel = 0; exp_open = 0;
        if (a[15]) begin
            exp_open = 1; exp_rom = '0; tag = "R10";
        end else if (a[14]) begin
            exp_sel = 1; exp_rom = {bank_num, a[13:0]}; tag = "R9";
        end else begin
            lo = a[7:0];
            tag = "R8";
            if (a[15:8] == 8'h01) begin
                tag = "R7";
                if (est == 1) begin lo[7] = 1'b1; tag = "R6"; end
                lo = unswap(lo);
            end
            exp_rom = {8'h00, a[13:8], lo};
        end
        chk(rom_addr == exp_rom && bank_sel == exp_sel && open_bus == exp_open, tag,
            {8'h0, open_bus, bank_sel, rom_addr}, {8'h0, exp_open, exp_sel, exp_rom});
    endtask

    task automatic op(input logic [15:0] a, input bit rd, input bit wr, input bit sk);
        int nst, ncnt;
        @(negedge clk);
        cpu_addr = a; rd_stb = rd; wr_stb = wr; skip_boot = sk;
        model_step(a, rd, wr, sk, nst, ncnt);
        #2;
        if (rd) check_map(a, nst);
        @(posedge clk); #1;
        rd_stb = 0; wr_stb = 0; skip_boot = 0;
        m_st = nst; m_cnt = ncnt;
        chk(state == 2'(m_st), "R5 stage", {30'd0, state}, m_st);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(posedge clk);
        #1; rst = 0;
        m_st = 0; m_cnt = 0;
        chk(state == 2'd0, "R1 reset stage", {30'd0, state}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bank_num = 8'h3C;
        do_reset();

        // R5 R6 R7: header sweep walks mono -> color -> unlocked
        for (int i = 0; i < 256; i++) op(16'h0100 + 16'(i), 1, 0, 0);
        chk(state == 2'd2, "R5 two advances", {30'd0, state}, 2);
        // R6: bit 7 no longer forced once unlocked
        op(16'h0105, 1, 0, 0);
        chk(rom_addr[7] == 1'b0, "R6 no force unlocked", {31'd0, rom_addr[7]}, 0);
        // R2: triggers ignored once unlocked
        op(16'hC000, 1, 0, 0);
        op(16'hD000, 0, 1, 0);
        chk(state == 2'd2, "R2 unlocked holds", {30'd0, state}, 2);

        // R3 boundary
        do_reset();
        op(16'hBFFF, 1, 0, 0);
        chk(state == 2'd0, "R3 below base", {30'd0, state}, 0);
        op(16'hC000, 1, 0, 0);
        chk(state == 2'd1, "R3 work-RAM read", {30'd0, state}, 1);
        op(16'h0180, 1, 0, 0);

        // R4 write window
        do_reset();
        op(16'hE000, 0, 1, 0);
        op(16'hBFFF, 0, 1, 0);
        chk(state == 2'd0, "R4 outside window", {30'd0, state}, 0);
        for (int i = 0; i < 60; i++) op(16'h0100, 0, 1, 0);
        chk(state == 2'd0, "R5 writes never count", {30'd0, state}, 0);
        op(16'hDFFF, 0, 1, 0);
        chk(state == 2'd1, "R4 work-RAM write", {30'd0, state}, 1);

        // R11 priority over a trigger read
        do_reset();
        op(16'hC123, 1, 0, 1);
        chk(state == 2'd2, "R11 skip priority", {30'd0, state}, 2);
        do_reset();
        op(16'hC123, 1, 0, 0);
        op(16'h0000, 0, 0, 1);
        chk(state == 2'd2, "R11 skip from color", {30'd0, state}, 2);

        // R8 R9 R10 and counting on aliased addresses: broad sweep
        do_reset();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bank_num = 8'(i) ^ 8'h5A;
            op(16'(i * 109), 1, 0, 0);
        end
        do_reset();
        for (int i = 0; i < 120; i++) op(16'h4100 + 16'(i & 8'h7F), 1, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule